// File: doc/BRIEF.md
# Priority Polling Interrupt Controller

This block lives on the processor side of a system in which several devices share one wired-OR interrupt request line. When that line is seen high, the controller works out which device raised it. It does not use a parallel priority encoder. Instead it puts device addresses, one per clock cycle, onto a small set of encoded polling lines. The address being offered is sampled by every device, and the addressed device answers on a shared response line if it has a pending request.

Addresses go out in fixed priority order. Device 0 is the most important and goes first, and the count rises from there. The first device that answers wins. Its number is presented with a one-cycle valid strobe. The controller then holds off all further polling until the processor acknowledges the result. If no device answers during a full sweep, the request was spurious: the controller raises a one-cycle flag and goes back to idle.

Top module: `poll_irq_ctrl`

## Requirements
- R1: After reset, poll_addr is 0 and poll_active, dev_valid and spurious are all low.
- R2: While idle with irq_line low, poll_active stays low and poll_addr stays 0.
- R3: In the cycle after irq_line is sampled high in idle, poll_active is high and poll_addr is 0.
- R4: While poll_active is high and no device has answered, poll_addr rises by exactly one each cycle.
- R5: The controller stops at the first address whose cycle has resp_line high. dev_id reports that address, which is the lowest-numbered pending device.
- R6: dev_valid is high for exactly one cycle, in the cycle after the answering address was on the polling lines. dev_id holds its value until the next result.
- R7: After a hit, poll_active stays low and no new dev_valid occurs until ack is sampled high, even if requests are pending.
- R8: If all N_DEV addresses are polled without an answer, spurious is high for exactly one cycle, in the cycle after address N_DEV-1. The controller then returns to idle with dev_valid low.
- R9: ack sampled while the controller is idle has no effect.
- R10: An answer on the last address, N_DEV-1, is reported as a hit with dev_valid, not as spurious.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line | input | 1 | Shared wired-OR interrupt request |
| resp_line | input | 1 | Shared response from the currently addressed device |
| ack | input | 1 | Processor acknowledge of a reported result |
| poll_addr | output | $clog2(N_DEV) | Encoded address on the polling lines |
| poll_active | output | 1 | High while a sweep is in progress |
| dev_valid | output | 1 | One-cycle strobe marking a new result on dev_id |
| dev_id | output | $clog2(N_DEV) | Number of the winning device |
| spurious | output | 1 | One-cycle flag for a sweep with no answer |

## Verification
The bench builds the controller with the default of eight devices, which gives three polling lines. With that setting every address can be reached in a short run. The bench covers hits on device 0 and device 7, on masks where several devices request at once, and a full spurious sweep of eight cycles that ends just past the last address. A device model answers from a pending mask on the live polling address, so priority order and latency are both checked against the lowest set bit of that mask.

// File: rtl/poll_pkg.sv
// Shared types for the polling interrupt controller.
// Assumes nothing beyond a synchronous design style.
package poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_HOLD = 2'd2
    } poll_state_t;
endpackage

// File: rtl/poll_addr_gen.sv
// Address counter for the polling lines. It counts up by one on each step
// while a sweep runs and falls back to zero once the sweep ends.
// Assumes ADDR_W >= 1 and that run is high only in the polling state.
module poll_addr_gen #(
    parameter int N_DEV  = 8,
    parameter int ADDR_W = $clog2(N_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_out,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_DEV - 1);

    logic [ADDR_W-1:0] cnt;

    // Counter: advance on step, hold on a hit, clear when not polling.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (step)         cnt <= cnt + 1'b1;
    end

    // Outputs: lines read zero outside a sweep.
    always_comb begin
        addr_q   = cnt;
        addr_out = run ? cnt : '0;
        last     = (cnt == LAST_ADDR);
    end

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
endmodule

// File: rtl/poll_fsm.sv
// Sequencer: idle until the shared request is seen, poll one address per
// cycle, then hold after a hit until acknowledged.
// Assumes resp_line is valid in the same cycle as the address it answers.
module poll_fsm
    import poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_line,
    input  logic resp_line,
    input  logic ack,
    input  logic last,
    output logic polling,
    output logic advance,
    output logic hit,
    output logic miss
);
    poll_state_t state, state_d;

    // Decode this cycle's outcome of the sweep.
    always_comb begin
        polling = (state == ST_POLL);
        hit     = polling && resp_line;
        miss    = polling && !resp_line && last;
        advance = polling && !resp_line && !last;
    end

    // Next-state selection.
    always_comb begin
        state_d = state;
        case (state)
            ST_IDLE: if (irq_line) state_d = ST_POLL;
            ST_POLL: if (hit) state_d = ST_HOLD;
                     else if (miss) state_d = ST_IDLE;
            ST_HOLD: if (ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // R7
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !ack) |=> (state == ST_HOLD));
    // R9
    idle_ignores_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !irq_line) |=> (state == ST_IDLE));
endmodule

// File: rtl/poll_report.sv
// Result registers: capture the winning address and raise the valid or
// spurious strobe for one cycle.
// Assumes hit and miss are never high together.
module poll_report #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              miss,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] dev_id,
    output logic              dev_valid,
    output logic              spurious
);
    // Strobes last a single cycle; the id is kept until the next hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_id    <= '0;
            dev_valid <= 1'b0;
            spurious  <= 1'b0;
        end else begin
            dev_valid <= hit;
            spurious  <= miss;
            if (hit) dev_id <= addr_in;
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |=> !dev_valid);
    // R8
    spur_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |=> !spurious);
    // R8
    spur_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(spurious && dev_valid));
endmodule

// File: rtl/poll_irq_ctrl.sv
// Priority polling interrupt controller top. It sweeps encoded device
// addresses in ascending order (device 0 first) after the shared request
// rises, and reports the first responder or flags a spurious request.
// Assumes N_DEV is a power of two and at least 2.
module poll_irq_ctrl #(
    parameter int N_DEV  = 8,
    localparam int ADDR_W = $clog2(N_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_line,
    input  logic              resp_line,
    input  logic              ack,
    output logic [ADDR_W-1:0] poll_addr,
    output logic              poll_active,
    output logic              dev_valid,
    output logic [ADDR_W-1:0] dev_id,
    output logic              spurious
);
    logic              polling, advance, hit, miss, last;
    logic [ADDR_W-1:0] addr_q;

    poll_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .resp_line(resp_line),
        .ack(ack), .last(last), .polling(polling), .advance(advance),
        .hit(hit), .miss(miss)
    );

    poll_addr_gen #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .run(polling), .step(advance),
        .addr_q(addr_q), .addr_out(poll_addr), .last(last)
    );

    poll_report #(.ADDR_W(ADDR_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .hit(hit), .miss(miss), .addr_in(addr_q),
        .dev_id(dev_id), .dev_valid(dev_valid), .spurious(spurious)
    );

    // Sweep indicator to the bus side.
    always_comb poll_active = polling;

    // R3
    sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poll_active) |-> (poll_addr == '0));
    // R7
    no_poll_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid |-> !poll_active);
endmodule

// File: tb/poll_irq_ctrl_tb.sv
module poll_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int AW = $clog2(N);

    typedef struct packed {
        logic [N-1:0] mask;
        logic [7:0]   exp_id;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'b0000_0001, 8'd0},
        '{8'b1000_0000, 8'd7},
        '{8'b0110_0000, 8'd5},
        '{8'b1111_1111, 8'd0},
        '{8'b1010_1000, 8'd3},
        '{8'b0001_0100, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack = 1'b0;
    logic spur_irq = 1'b0;
    logic [N-1:0] pend = '0;
    logic irq_line, resp_line;
    logic [AW-1:0] poll_addr, dev_id;
    logic poll_active, dev_valid, spurious;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    assign irq_line  = (|pend) | spur_irq;
    assign resp_line = poll_active && pend[poll_addr];

    poll_irq_ctrl #(.N_DEV(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .resp_line(resp_line),
        .ack(ack), .poll_addr(poll_addr), .poll_active(poll_active),
        .dev_valid(dev_valid), .dev_id(dev_id), .spurious(spurious)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Drive a pending mask, follow the sweep, check result and handshake.
    task automatic run_hit(input logic [N-1:0] mask, input int exp_id);
        int cyc = 0;
        pend = mask;
        while (!dev_valid && !spurious && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) chk(poll_active && poll_addr == 0, "R3 sweep start", int'(poll_addr), 0);
            else if (poll_active) chk(int'(poll_addr) == cyc - 1, "R4 address step", int'(poll_addr), cyc - 1);
        end
        chk(dev_valid && !spurious, "R10/R5 hit reported", int'(spurious), 0);
        chk(int'(dev_id) == exp_id, "R5 winner id", int'(dev_id), exp_id);
        chk(cyc == exp_id + 2, "R6 valid latency", cyc, exp_id + 2);
        pend = '1;
        @(negedge clk);
        chk(!dev_valid, "R6 single-cycle valid", int'(dev_valid), 0);
        chk(int'(dev_id) == exp_id, "R6 id held", int'(dev_id), exp_id);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!poll_active && !dev_valid, "R7 hold before ack", int'(poll_active), 0);
        end
        pend = '0;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        chk(!poll_active && poll_addr == 0, "R2 idle after ack", int'(poll_addr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(poll_addr == 0 && !poll_active && !dev_valid && !spurious,
            "R1 reset state", int'(poll_active), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!poll_active && poll_addr == 0, "R2 idle quiet", int'(poll_addr), 0);

        foreach (VECS[i]) run_hit(VECS[i].mask, int'(VECS[i].exp_id));

        // R10 last device alone
        run_hit(8'b1000_0000, N - 1);

        // R9 ack in idle
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk(!poll_active && !dev_valid && !spurious, "R9 ack in idle ignored",
                int'(poll_active), 0);
        end

        // R8 spurious sweep
        begin
            int cyc = 0;
            spur_irq = 1'b1;
            while (!spurious && !dev_valid && cyc < 40) begin
                @(negedge clk);
                cyc++;
            end
            spur_irq = 1'b0;
            chk(spurious && !dev_valid, "R8 spurious flag", int'(spurious), 1);
            chk(cyc == N + 1, "R8 spurious latency", cyc, N + 1);
            chk(!poll_active, "R8 back to idle", int'(poll_active), 0);
            @(negedge clk);
            chk(!spurious && !poll_active, "R8 single-cycle spurious", int'(spurious), 0);
        end

        // R5 after spurious: a normal hit still works
        run_hit(8'b0100_0010, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule